// File: doc/BRIEF.md
# Run-Test Signature and Pattern Engine

This block sits beside the sixteen data cells of one transfer direction in a boundary-scan style test wrapper for an eight-lane bidirectional buffer. It holds a serially loaded control word and uses it to choose a self-test operation. The operation runs while the test controller idles with the run-test instruction active. Each step sees the current cell contents and the pin inputs. It then produces next-state values and a write strobe for each group of cells. The cell storage itself lives outside the block. It loads those values on the rising test-clock edge and moves them to the pins on the falling edge.

The control word is `LANES+3` bits long. The low three bits are the operation code. The remaining bits are per-lane masks, with mask bit `3+k` belonging to pin `k`. The word is loaded through a shift path that ends in a separate active copy. While a new word is shifted in, the operation in force does not change. Five operations exist. The first samples the inputs and inverts the outputs. The second is a 16-bit pseudo-random generator. The third is a 16-bit masked signature compressor. The fourth runs an 8-bit signature and an 8-bit generator side by side. The fifth runs an 8-bit signature alongside an 8-bit up-counter whose carry increments the output cells on the far side. The engine only acts while exactly one side's outputs are enabled.

Top module: `sigpat_engine`

## Requirements
- R1: After reset, the scan path and the active control word both hold 0x002, which selects the 16-bit signature mode with every mask bit clear. Shifting out the word gives bit 0 first, so the serial sequence begins 0, 1, 0.
- R2: While `cfg_shift` is high, `cfg_si` enters bit 10 and every bit moves one place toward bit 0. `cfg_so` always shows bit 0 and changes only after a shift. A pulse on `cfg_update` copies the scan path into the active word. Without that pulse, the operation in force does not change.
- R3: While `cfg_capture` is high, the scan path keeps its contents, even if `cfg_shift` is high in the same cycle.
- R4: No write strobe is raised while `run_en` is low, or while `drv_a` equals `drv_b`. In those cycles every cell keeps its value.
- R5: With `drv_b`=1 and `drv_a`=0 the flow is A to B: the input group is `ai_cell`, the output group is `bo_cell`, and the pins used are `a_pin`. With `drv_a`=1 and `drv_b`=0 the flow is B to A, using `bi_cell`, `ao_cell` and `b_pin`. The input cells of the inactive side are never written.
- R6: For operation codes ending in 00, one step loads the input group with the raw pins (masks not applied) and inverts the output group.
- R7: For codes ending in 01, the 16-bit value {output group, input group} shifts one place toward its MSB. The new bit 0 is the XOR of bits 15, 11, 2 and 0.
- R8: For code 010 (or 110), each step is the R7 step with the masked pins XORed into the low eight bits. A mask bit of 1 stops its pin from affecting the signature.
- R9: For code 011, each group shifts toward its own MSB. The new bit 0 of a group is the XOR of its bits 7, 5, 4 and 3. The input group is also XORed with the masked pins.
- R10: For code 111, the input group steps as in R9. The output group increments by one modulo 256. Only when it wraps from 0xFF are the output cells of the other side incremented; otherwise they are not written.
- R11: In the generator modes, an all-zero seed stays all-zero when the pins add nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; state advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift | input | 1 | Shift strobe for the control scan path |
| cfg_capture | input | 1 | Capture strobe; holds the scan path |
| cfg_update | input | 1 | Copies the scan path into the active control word |
| cfg_si | input | 1 | Serial data into the control scan path |
| cfg_so | output | 1 | Serial data out (bit 0 of the scan path) |
| run_en | input | 1 | High in the idle state with the run-test instruction active |
| drv_a | input | 1 | A-side output enable value |
| drv_b | input | 1 | B-side output enable value |
| a_pin | input | 8 | A-side pin inputs |
| b_pin | input | 8 | B-side pin inputs |
| ai_cell | input | 8 | Current A input cells |
| bi_cell | input | 8 | Current B input cells |
| ao_cell | input | 8 | Current A output cells |
| bo_cell | input | 8 | Current B output cells |
| ai_next | output | 8 | Next value for the A input cells |
| bi_next | output | 8 | Next value for the B input cells |
| ao_next | output | 8 | Next value for the A output cells |
| bo_next | output | 8 | Next value for the B output cells |
| ai_we | output | 1 | Write strobe for the A input cells |
| bi_we | output | 1 | Write strobe for the B input cells |
| ao_we | output | 1 | Write strobe for the A output cells |
| bo_we | output | 1 | Write strobe for the B output cells |

## Verification
The assertions assume that the cell vectors on the inputs are exactly the values the external storage loaded from the block's own next values. The carry and pairing properties rely on this. They also assume that the enable pair and `run_en` change only between clock edges. The bench meets both conditions in two ways. It models the cell storage itself and loads `*_next` on every strobe. It drives every control input on the falling edge. It preloads seeds only while `run_en` is low, so a seed never overlaps a step.

// File: rtl/sigpat_pkg.sv
package sigpat_pkg;

  typedef enum logic [2:0] {
    MD_TOGGLE  = 3'd0,
    MD_PATGEN  = 3'd1,
    MD_SIGNAT  = 3'd2,
    MD_SIG_PAT = 3'd3,
    MD_SIG_CNT = 3'd4
  } run_mode_e;

  localparam int unsigned OPC_W = 3;

endpackage

// File: rtl/sigpat_cfg_chain.sv
module sigpat_cfg_chain #(
  parameter int unsigned LANES = 8,
  localparam int unsigned CW = LANES + sigpat_pkg::OPC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          capture_en,
  input  logic          update_en,
  input  logic          ser_in,
  output logic          ser_out,
  output logic [CW-1:0] active_cfg
);
  localparam logic [CW-1:0] CFG_RST = CW'(3'b010);

  logic [CW-1:0] scan_q, scan_d;
  logic [CW-1:0] act_q,  act_d;

  always_comb begin
    scan_d = scan_q;
    if (capture_en)    scan_d = scan_q;
    else if (shift_en) scan_d = {ser_in, scan_q[CW-1:1]};
  end

  always_comb begin
    act_d = act_q;
    if (update_en) act_d = scan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= CFG_RST;
      act_q  <= CFG_RST;
    end else begin
      scan_q <= scan_d;
      act_q  <= act_d;
    end
  end

  assign ser_out    = scan_q[0];
  assign active_cfg = act_q;
endmodule

// File: rtl/sigpat_decode.sv
module sigpat_decode (
  input  logic                  run_en,
  input  logic                  drv_a,
  input  logic                  drv_b,
  input  logic [2:0]            opcode,
  output sigpat_pkg::run_mode_e mode,
  output logic                  active,
  output logic                  a_to_b
);
  import sigpat_pkg::*;

  always_comb begin
    unique case (opcode[1:0])
      2'b00:   mode = MD_TOGGLE;
      2'b01:   mode = MD_PATGEN;
      2'b10:   mode = MD_SIGNAT;
      default: mode = opcode[2] ? MD_SIG_CNT : MD_SIG_PAT;
    endcase
  end

  assign active = run_en & (drv_a ^ drv_b);
  assign a_to_b = drv_b & ~drv_a;
endmodule

// File: rtl/sigpat_datapath.sv
module sigpat_datapath #(
  parameter int unsigned LANES      = 8,
  parameter logic [2*LANES-1:0] TAPS_WIDE   = 16'h8805,
  parameter logic [LANES-1:0]   TAPS_NARROW = 8'hB8
) (
  input  sigpat_pkg::run_mode_e mode,
  input  logic                  active,
  input  logic                  a_to_b,
  input  logic [LANES-1:0]      mask,
  input  logic [LANES-1:0]      a_pin,
  input  logic [LANES-1:0]      b_pin,
  input  logic [LANES-1:0]      ai_cell,
  input  logic [LANES-1:0]      bi_cell,
  input  logic [LANES-1:0]      ao_cell,
  input  logic [LANES-1:0]      bo_cell,
  output logic [LANES-1:0]      ai_next,
  output logic [LANES-1:0]      bi_next,
  output logic [LANES-1:0]      ao_next,
  output logic [LANES-1:0]      bo_next,
  output logic                  ai_we,
  output logic                  bi_we,
  output logic                  ao_we,
  output logic                  bo_we
);
  import sigpat_pkg::*;

  localparam int unsigned WW = 2 * LANES;
  localparam logic [LANES-1:0] ONE = LANES'(1);

  logic [LANES-1:0] in_c, out_c, opp_c, pins, pins_m;
  logic [LANES-1:0] in_n, out_n, opp_n;
  logic [WW-1:0]    wide, wide_sh;
  logic [LANES-1:0] in_sh, out_sh;
  logic             carry, opp_wr;

  assign in_c  = a_to_b ? ai_cell : bi_cell;
  assign out_c = a_to_b ? bo_cell : ao_cell;
  assign opp_c = a_to_b ? ao_cell : bo_cell;
  assign pins  = a_to_b ? a_pin   : b_pin;

  for (genvar g = 0; g < LANES; g++) begin : g_lane_mask
    assign pins_m[g] = pins[g] & ~mask[g];
  end

  assign wide    = {out_c, in_c};
  assign wide_sh = {wide[WW-2:0], ^(wide & TAPS_WIDE)};
  assign in_sh   = {in_c[LANES-2:0],  ^(in_c  & TAPS_NARROW)};
  assign out_sh  = {out_c[LANES-2:0], ^(out_c & TAPS_NARROW)};
  assign carry   = &out_c;

  always_comb begin
    in_n   = in_c;
    out_n  = out_c;
    opp_n  = opp_c;
    opp_wr = 1'b0;
    unique case (mode)
      MD_TOGGLE: begin
        in_n  = pins;
        out_n = ~out_c;
      end
      MD_PATGEN: begin
        {out_n, in_n} = wide_sh;
      end
      MD_SIGNAT: begin
        {out_n, in_n} = wide_sh ^ {{LANES{1'b0}}, pins_m};
      end
      MD_SIG_PAT: begin
        in_n  = in_sh ^ pins_m;
        out_n = out_sh;
      end
      MD_SIG_CNT: begin
        in_n   = in_sh ^ pins_m;
        out_n  = out_c + ONE;
        opp_n  = opp_c + ONE;
        opp_wr = carry;
      end
      default: begin
        in_n = in_c;
      end
    endcase
  end

  always_comb begin
    ai_next = ai_cell;
    bi_next = bi_cell;
    ao_next = ao_cell;
    bo_next = bo_cell;
    ai_we   = 1'b0;
    bi_we   = 1'b0;
    ao_we   = 1'b0;
    bo_we   = 1'b0;
    if (a_to_b) begin
      ai_next = in_n;
      bo_next = out_n;
      ao_next = opp_n;
      ai_we   = active;
      bo_we   = active;
      ao_we   = active & opp_wr;
    end else begin
      bi_next = in_n;
      ao_next = out_n;
      bo_next = opp_n;
      bi_we   = active;
      ao_we   = active;
      bo_we   = active & opp_wr;
    end
  end
endmodule

// File: rtl/sigpat_engine.sv
module sigpat_engine #(
  parameter int unsigned LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_shift,
  input  logic             cfg_capture,
  input  logic             cfg_update,
  input  logic             cfg_si,
  output logic             cfg_so,
  input  logic             run_en,
  input  logic             drv_a,
  input  logic             drv_b,
  input  logic [LANES-1:0] a_pin,
  input  logic [LANES-1:0] b_pin,
  input  logic [LANES-1:0] ai_cell,
  input  logic [LANES-1:0] bi_cell,
  input  logic [LANES-1:0] ao_cell,
  input  logic [LANES-1:0] bo_cell,
  output logic [LANES-1:0] ai_next,
  output logic [LANES-1:0] bi_next,
  output logic [LANES-1:0] ao_next,
  output logic [LANES-1:0] bo_next,
  output logic             ai_we,
  output logic             bi_we,
  output logic             ao_we,
  output logic             bo_we
);
  import sigpat_pkg::*;

  localparam int unsigned CW = LANES + OPC_W;

  logic            rst_m, rst_s;
  logic [CW-1:0]   active_cfg;
  run_mode_e       mode;
  logic            active, a_to_b;

  // reset synchronizer: asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  sigpat_cfg_chain #(.LANES(LANES)) u_chain (
    .clk        (clk),
    .rst_n      (rst_s),
    .shift_en   (cfg_shift),
    .capture_en (cfg_capture),
    .update_en  (cfg_update),
    .ser_in     (cfg_si),
    .ser_out    (cfg_so),
    .active_cfg (active_cfg)
  );

  sigpat_decode u_dec (
    .run_en (run_en & rst_s),
    .drv_a  (drv_a),
    .drv_b  (drv_b),
    .opcode (active_cfg[OPC_W-1:0]),
    .mode   (mode),
    .active (active),
    .a_to_b (a_to_b)
  );

  sigpat_datapath #(.LANES(LANES)) u_dp (
    .mode    (mode),
    .active  (active),
    .a_to_b  (a_to_b),
    .mask    (active_cfg[CW-1:OPC_W]),
    .a_pin   (a_pin),
    .b_pin   (b_pin),
    .ai_cell (ai_cell),
    .bi_cell (bi_cell),
    .ao_cell (ao_cell),
    .bo_cell (bo_cell),
    .ai_next (ai_next),
    .bi_next (bi_next),
    .ao_next (ao_next),
    .bo_next (bo_next),
    .ai_we   (ai_we),
    .bi_we   (bi_we),
    .ao_we   (ao_we),
    .bo_we   (bo_we)
  );
endmodule

// File: rtl/sigpat_engine_chk.sv
module sigpat_engine_chk #(
  parameter int unsigned LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_shift,
  input logic             cfg_so,
  input logic             run_en,
  input logic             drv_a,
  input logic             drv_b,
  input logic [LANES-1:0] ao_cell,
  input logic [LANES-1:0] bo_cell,
  input logic             ai_we,
  input logic             bi_we,
  input logic             ao_we,
  input logic             bo_we
);
  // R4
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en || (drv_a == drv_b)) |-> !(ai_we || bi_we || ao_we || bo_we));

  // R5
  side_a_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ai_we |-> (drv_b && !drv_a && bo_we));

  // R5
  side_b_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bi_we |-> (drv_a && !drv_b && ao_we));

  // R10
  carry_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ao_we && drv_b && !drv_a) |-> (&bo_cell));

  // R10
  carry_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_we && drv_a && !drv_b) |-> (&ao_cell));

  // R2
  so_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_shift |=> $stable(cfg_so));
endmodule

bind sigpat_engine sigpat_engine_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_shift (cfg_shift),
  .cfg_so    (cfg_so),
  .run_en    (run_en),
  .drv_a     (drv_a),
  .drv_b     (drv_b),
  .ao_cell   (ao_cell),
  .bo_cell   (bo_cell),
  .ai_we     (ai_we),
  .bi_we     (bi_we),
  .ao_we     (ao_we),
  .bo_we     (bo_we)
);

// File: tb/test_sigpat_engine.sv
`timescale 1ns/1ps
module test_sigpat_engine;
  logic clk = 1'b0;
  logic rst_n, cfg_shift, cfg_capture, cfg_update, cfg_si, cfg_so;
  logic run_en, drv_a, drv_b;
  logic [7:0] a_pin, b_pin;
  logic [7:0] s_ai, s_bi, s_ao, s_bo;
  logic [7:0] ai_next, bi_next, ao_next, bo_next;
  logic ai_we, bi_we, ao_we, bo_we;
  logic pl_en;
  logic [7:0] pl_ai, pl_bi, pl_ao, pl_bo;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sigpat_engine i_sigpat_engine (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_capture(cfg_capture),
    .cfg_update(cfg_update), .cfg_si(cfg_si), .cfg_so(cfg_so), .run_en(run_en),
    .drv_a(drv_a), .drv_b(drv_b), .a_pin(a_pin), .b_pin(b_pin),
    .ai_cell(s_ai), .bi_cell(s_bi), .ao_cell(s_ao), .bo_cell(s_bo),
    .ai_next(ai_next), .bi_next(bi_next), .ao_next(ao_next), .bo_next(bo_next),
    .ai_we(ai_we), .bi_we(bi_we), .ao_we(ao_we), .bo_we(bo_we));

  // bench-side cell storage
  always @(posedge clk) begin
    if (pl_en) begin
      s_ai <= pl_ai; s_bi <= pl_bi; s_ao <= pl_ao; s_bo <= pl_bo;
    end else begin
      if (ai_we) s_ai <= ai_next;
      if (bi_we) s_bi <= bi_next;
      if (ao_we) s_ao <= ao_next;
      if (bo_we) s_bo <= bo_next;
    end
  end

  function automatic [15:0] m16(input [15:0] v);
    return {v[14:0], v[15] ^ v[11] ^ v[2] ^ v[0]};
  endfunction
  function automatic [7:0] m8(input [7:0] v);
    return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
  endfunction

  task automatic chk(input string req, input [15:0] act, input [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic preload(input [7:0] ai, input [7:0] bi, input [7:0] ao, input [7:0] bo);
    pl_ai = ai; pl_bi = bi; pl_ao = ao; pl_bo = bo; pl_en = 1'b1;
    @(negedge clk); pl_en = 1'b0;
  endtask

  task automatic steps(input int n);
    run_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); run_en = 1'b0;
  endtask

  task automatic scan_cfg(input [10:0] val, input bit upd, output [10:0] old);
    for (int i = 0; i < 11; i++) begin
      cfg_shift = 1'b1; cfg_si = val[i];
      #0.5 old[i] = cfg_so;
      @(negedge clk);
    end
    cfg_shift = 1'b0;
    if (upd) begin
      cfg_update = 1'b1; @(negedge clk); cfg_update = 1'b0;
    end
  endtask

  task automatic t_reset_mode;
    drv_a = 0; drv_b = 1; a_pin = 8'hFF;
    preload(8'h21, 8'h44, 8'h66, 8'h87);
    steps(1);
    chk("R1 default 16-bit signature", {s_bo, s_ai}, m16(16'h8721) ^ 16'h00FF);
  endtask

  task automatic t_reset_readback;
    logic [10:0] old;
    scan_cfg(11'h002, 1, old);
    chk("R1 scan path reset value", {5'd0, old}, 16'h0002);
  endtask

  task automatic t_no_update_capture;
    logic [10:0] old;
    scan_cfg(11'h001, 0, old);
    drv_a = 0; drv_b = 1; a_pin = 8'h0F;
    preload(8'h10, 8'h00, 8'h00, 8'h01);
    steps(1);
    chk("R2 mode kept without update", {s_bo, s_ai}, m16(16'h0110) ^ 16'h000F);
    cfg_capture = 1'b1; cfg_shift = 1'b1; cfg_si = 1'b1;
    @(negedge clk);
    cfg_capture = 1'b0; cfg_shift = 1'b0;
    scan_cfg(11'h001, 1, old);
    chk("R3 capture held scan path", {5'd0, old}, 16'h0001);
  endtask

  task automatic t_patgen_ba;
    logic [15:0] e;
    drv_a = 1; drv_b = 0; b_pin = 8'hFF;
    preload(8'h3C, 8'h01, 8'h80, 8'hC3);
    steps(4);
    e = 16'h8001;
    for (int i = 0; i < 4; i++) e = m16(e);
    chk("R7 16-bit pattern B to A", {s_ao, s_bi}, e);
    chk("R5 inactive side untouched", {s_bo, s_ai}, 16'hC33C);
  endtask

  task automatic t_zero_seed;
    logic [10:0] old;
    preload(8'h00, 8'h00, 8'h00, 8'h77);
    steps(3);
    chk("R11 zero seed 16-bit", {s_ao, s_bi}, 16'h0000);
    scan_cfg(11'h003, 1, old);
    b_pin = 8'h00;
    preload(8'h00, 8'h00, 8'h00, 8'h77);
    steps(3);
    chk("R11 zero seed 8-bit", {s_ao, s_bi}, 16'h0000);
  endtask

  task automatic t_topsip;
    logic [10:0] old;
    scan_cfg(11'h004, 1, old);
    drv_a = 0; drv_b = 1; a_pin = 8'hC3; b_pin = 8'h99;
    preload(8'h00, 8'h5E, 8'h71, 8'h55);
    steps(1);
    chk("R6 inputs sampled", {8'h00, s_ai}, 16'h00C3);
    chk("R6 outputs toggled", {8'h00, s_bo}, 16'h00AA);
    chk("R5 B input and A output kept", {s_bi, s_ao}, 16'h5E71);
  endtask

  task automatic t_psa_mask;
    logic [10:0] old;
    logic [15:0] e;
    logic [15:0] r1;
    scan_cfg({8'hF0, 3'b010}, 1, old);
    drv_a = 0; drv_b = 1; a_pin = 8'hFF;
    preload(8'h5A, 8'h00, 8'h00, 8'h3C);
    steps(3);
    e = 16'h3C5A;
    for (int i = 0; i < 3; i++) e = m16(e) ^ 16'h000F;
    r1 = {s_bo, s_ai};
    chk("R8 masked 16-bit signature", r1, e);
    a_pin = 8'h0F;
    preload(8'h5A, 8'h00, 8'h00, 8'h3C);
    steps(3);
    chk("R8 masked pins have no effect", {s_bo, s_ai}, e);
  endtask

  task automatic t_sig_pat8;
    logic [10:0] old;
    logic [7:0] ei, eo;
    scan_cfg({8'h01, 3'b011}, 1, old);
    drv_a = 1; drv_b = 0; b_pin = 8'hA5;
    preload(8'h00, 8'h12, 8'h34, 8'h00);
    steps(3);
    ei = 8'h12; eo = 8'h34;
    for (int i = 0; i < 3; i++) begin
      ei = m8(ei) ^ 8'hA4;
      eo = m8(eo);
    end
    chk("R9 8-bit signature", {8'h00, s_bi}, {8'h00, ei});
    chk("R9 8-bit pattern", {8'h00, s_ao}, {8'h00, eo});
  endtask

  task automatic t_count;
    logic [10:0] old;
    scan_cfg(11'h007, 1, old);
    drv_a = 0; drv_b = 1; a_pin = 8'h00;
    preload(8'h00, 8'h00, 8'h07, 8'hFE);
    steps(1);
    chk("R10 count without carry", {s_ao, s_bo}, 16'h07FF);
    steps(1);
    chk("R10 count wraps and carries", {s_ao, s_bo}, 16'h0800);
    steps(1);
    chk("R10 no carry after wrap", {s_ao, s_bo}, 16'h0801);
  endtask

  task automatic t_gating;
    drv_a = 1; drv_b = 1;
    preload(8'h11, 8'h22, 8'h33, 8'h44);
    steps(2);
    chk("R4 both enabled: cells kept", {s_ai, s_bi}, 16'h1122);
    chk("R4 both enabled: outputs kept", {s_ao, s_bo}, 16'h3344);
    drv_a = 0; drv_b = 1; run_en = 0;
    repeat (3) @(negedge clk);
    chk("R4 run_en low: cells kept", {s_ai, s_bo}, 16'h1144);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_shift = 0; cfg_capture = 0; cfg_update = 0; cfg_si = 0;
    run_en = 0; drv_a = 0; drv_b = 0; a_pin = 0; b_pin = 0; pl_en = 0;
    pl_ai = 0; pl_bi = 0; pl_ao = 0; pl_bo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset_mode();
    t_reset_readback();
    t_no_update_capture();
    t_patgen_ba();
    t_zero_seed();
    t_topsip();
    t_psa_mask();
    t_sig_pat8();
    t_count();
    t_gating();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule